// File: doc/BRIEF.md
# Reset Source Aggregator with Cause Flags

This block gathers every reset request in the device into one active-high system reset. The requests are power-on, brown-out, the external clear pin, the software reset instruction, the watchdog timeout, configuration mismatch, trap conflict and a group of illegal-condition requests. The illegal-condition group covers illegal opcode, use of an uninitialized working register and a security violation. The clear pin is active low and passes through a glitch filter first. Once the last request goes away, the system reset is held for a fixed stretch of cycles so that downstream logic sees a clean release.

Next to the reset output, the block keeps a 16-bit cause register with one sticky flag per reset type. Software can read it on `cause_flags` and overwrite it through a simple write port. Warm resets never clear the flags. A power-on request leaves only the power-on and brown-out flags set.

The block also classifies each reset as cold (power-on or brown-out) or warm (any other source). The clock-source selection used after the reset follows from that class: the configuration oscillator field after a cold reset, and the current oscillator field after a warm one.

Top module: `reset_cause_hub`

## Requirements
- R1: `sys_rst` is 1 after any clock edge that samples at least one active request (power-on, brown-out, software, watchdog, configuration mismatch, trap conflict, any illegal-condition input, or the filtered clear pin).
- R2: Once an edge samples no request, `sys_rst` stays 1 for exactly 8 more edges. It falls on the 9th edge after the last edge that sampled a request.
- R3: The clear pin `clr_pin_n` counts as a request only after 4 consecutive edges have sampled it low. It stays a request until an edge samples it high. A low pulse shorter than 4 cycles has no effect on `sys_rst` or on the flags.
- R4: Each request sets its own flag on the edge that samples it. The positions are: bit 0 power-on, bit 1 brown-out, bit 4 watchdog, bit 6 software, bit 7 clear pin, bit 8 configuration mismatch, bit 10 any illegal-condition input, bit 15 trap conflict.
- R5: When an edge samples no request and no write, the flags keep their value. This includes edges during a warm reset.
- R6: An edge that samples `por_req` high leaves `cause_flags` equal to 16'h0003, whatever other requests or writes arrive in that cycle.
- R7: A write (`cause_wr_en`=1) loads `cause_wr_data` AND 16'h85D3, so reserved bits always read 0. Writes never assert `sys_rst`, and they are also accepted while `sys_rst` is 1.
- R8: Requests sampled together set all their flags on the same edge. A write in that same cycle is applied first, and the hardware sets are then ORed on top of it.
- R9: `cold_rst` becomes 1 on an edge that samples power-on or brown-out. It becomes 0 on an edge that samples only warm requests while `sys_rst` is 0. Otherwise it holds, so a warm request arriving during a cold reset leaves it at 1.
- R10: `clk_src_sel` equals `cfg_osc_sel` while `cold_rst` is 1 and `cur_osc_sel` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request; also the synchronous clear of the block |
| bor_req | input | 1 | Brown-out request |
| clr_pin_n | input | 1 | External clear pin, active low, glitch filtered |
| swrst_req | input | 1 | Software reset instruction request |
| wdt_req | input | 1 | Watchdog timeout request |
| cfg_mismatch_req | input | 1 | Configuration mismatch request |
| trap_conflict_req | input | 1 | Trap conflict request |
| illegal_op_req | input | 1 | Illegal opcode request |
| uninit_reg_req | input | 1 | Uninitialized working register request |
| security_req | input | 1 | Security violation request |
| cause_wr_en | input | 1 | Software write strobe for the cause flags |
| cause_wr_data | input | 16 | Software write data |
| cfg_osc_sel | input | 3 | Oscillator field from configuration |
| cur_osc_sel | input | 3 | Current oscillator field |
| sys_rst | output | 1 | System reset, active high |
| cold_rst | output | 1 | 1 when the latest reset was cold |
| clk_src_sel | output | 3 | Clock source selection used after reset |
| cause_flags | output | 16 | Sticky reset cause flags |

## Verification
The assertions assume that every request input and the clear pin change only between clock edges and hold steady at each edge. They also assume that `por_req` is high from time zero, so that all state is defined before any property is enabled, and they stay disabled while `por_req` is 1. The stimulus drives all inputs on the falling edge and begins with several power-on cycles. It moves one source at a time, except in the deliberate simultaneous and write-collision cases, and it waits for `sys_rst` to return to 0 before each new case, so that every expected stretch length and flag value follows from a single event.

// File: rtl/rcause_pkg.sv
`timescale 1ns/1ps
package rcause_pkg;
    localparam int CAUSE_W = 16;

    // flag positions inside the cause register
    localparam int B_POR  = 0;
    localparam int B_BOR  = 1;
    localparam int B_WDT  = 4;
    localparam int B_SW   = 6;
    localparam int B_PIN  = 7;
    localparam int B_CFG  = 8;
    localparam int B_ILL  = 10;
    localparam int B_TRAP = 15;

    localparam logic [CAUSE_W-1:0] IMPL_MASK = CAUSE_W'((1 << B_POR) | (1 << B_BOR) | (1 << B_WDT)
        | (1 << B_SW) | (1 << B_PIN) | (1 << B_CFG) | (1 << B_ILL) | (1 << B_TRAP));
    localparam logic [CAUSE_W-1:0] POR_VALUE = CAUSE_W'((1 << B_POR) | (1 << B_BOR));

    // one entry per reset type after qualification
    typedef struct packed {
        logic por;
        logic bor;
        logic pin;
        logic sw;
        logic wdt;
        logic cfg;
        logic trap;
        logic ill;
    } req_vec_t;
endpackage

// File: rtl/rc_pin_filter.sv
`timescale 1ns/1ps
module rc_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic pin_n,
    output logic req
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LIM = CW'(FILT_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || pin_n) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign req = (st_q.cnt == LIM);
endmodule

// File: rtl/rc_rst_seq.sv
`timescale 1ns/1ps
module rc_rst_seq #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic any_req,
    input  logic cold_req,
    output logic sys_rst,
    output logic cold
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          rst;
        logic          cold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (any_req) begin
            st_d.hold = HOLD_V;
            st_d.rst  = 1'b1;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
            st_d.rst  = 1'b1;
        end else begin
            st_d.rst  = 1'b0;
        end

        // class is decided when a reset starts; a cold source always wins
        if (cold_req) begin
            st_d.cold = 1'b1;
        end else if (any_req && !st_q.rst) begin
            st_d.cold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sys_rst = st_q.rst;
    assign cold    = st_q.cold;
endmodule

// File: rtl/rc_cause_reg.sv
`timescale 1ns/1ps
module rc_cause_reg
    import rcause_pkg::*;
(
    input  logic               clk,
    input  req_vec_t           req,
    input  logic               wr_en,
    input  logic [CAUSE_W-1:0] wr_data,
    output logic [CAUSE_W-1:0] flags
);
    typedef struct packed {
        logic [CAUSE_W-1:0] flags;
    } st_t;

    st_t                st_d, st_q;
    logic [CAUSE_W-1:0] set_mask;

    always_comb begin
        set_mask         = '0;
        set_mask[B_BOR]  = req.bor;
        set_mask[B_PIN]  = req.pin;
        set_mask[B_SW]   = req.sw;
        set_mask[B_WDT]  = req.wdt;
        set_mask[B_CFG]  = req.cfg;
        set_mask[B_TRAP] = req.trap;
        set_mask[B_ILL]  = req.ill;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.flags = wr_data & IMPL_MASK;
        end
        st_d.flags = st_d.flags | set_mask;
        if (req.por) begin
            st_d.flags = POR_VALUE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/reset_cause_hub.sv
`timescale 1ns/1ps
module reset_cause_hub
    import rcause_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int HOLD     = 8,
    parameter int OSC_W    = 3
) (
    input  logic               clk,
    input  logic               por_req,
    input  logic               bor_req,
    input  logic               clr_pin_n,
    input  logic               swrst_req,
    input  logic               wdt_req,
    input  logic               cfg_mismatch_req,
    input  logic               trap_conflict_req,
    input  logic               illegal_op_req,
    input  logic               uninit_reg_req,
    input  logic               security_req,
    input  logic               cause_wr_en,
    input  logic [CAUSE_W-1:0] cause_wr_data,
    input  logic [OSC_W-1:0]   cfg_osc_sel,
    input  logic [OSC_W-1:0]   cur_osc_sel,
    output logic               sys_rst,
    output logic               cold_rst,
    output logic [OSC_W-1:0]   clk_src_sel,
    output logic [CAUSE_W-1:0] cause_flags
);
    localparam int REQ_N = $bits(req_vec_t);

    logic             pin_req;
    req_vec_t         req;
    logic [REQ_N-1:0] req_flat;
    logic             any_req;

    rc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .clr   (por_req),
        .pin_n (clr_pin_n),
        .req   (pin_req)
    );

    always_comb begin
        req.por  = por_req;
        req.bor  = bor_req;
        req.pin  = pin_req;
        req.sw   = swrst_req;
        req.wdt  = wdt_req;
        req.cfg  = cfg_mismatch_req;
        req.trap = trap_conflict_req;
        req.ill  = illegal_op_req | uninit_reg_req | security_req;
    end

    assign req_flat = req;
    assign any_req  = |req_flat;

    rc_rst_seq #(.HOLD(HOLD)) u_seq (
        .clk      (clk),
        .any_req  (any_req),
        .cold_req (por_req | bor_req),
        .sys_rst  (sys_rst),
        .cold     (cold_rst)
    );

    rc_cause_reg u_cause (
        .clk     (clk),
        .req     (req),
        .wr_en   (cause_wr_en),
        .wr_data (cause_wr_data),
        .flags   (cause_flags)
    );

    assign clk_src_sel = cold_rst ? cfg_osc_sel : cur_osc_sel;
endmodule

// File: rtl/reset_cause_hub_chk.sv
`timescale 1ns/1ps
module reset_cause_hub_chk
    import rcause_pkg::*;
(
    input logic               clk,
    input logic               por_req,
    input logic               bor_req,
    input logic               clr_pin_n,
    input logic               swrst_req,
    input logic               wdt_req,
    input logic               cfg_mismatch_req,
    input logic               trap_conflict_req,
    input logic               illegal_op_req,
    input logic               uninit_reg_req,
    input logic               security_req,
    input logic               cause_wr_en,
    input logic               sys_rst,
    input logic               cold_rst,
    input logic [CAUSE_W-1:0] cause_flags
);
    logic warm_any;
    assign warm_any = swrst_req | wdt_req | cfg_mismatch_req | trap_conflict_req
                    | illegal_op_req | uninit_reg_req | security_req;

    // R1
    a_r1_src_asserts: assert property (@(posedge clk) disable iff (por_req)
        (warm_any || bor_req) |=> sys_rst);

    // R2
    a_r2_fall_needs_quiet: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> !$past(warm_any || bor_req));

    // R4
    a_r4_wdt_flag: assert property (@(posedge clk) disable iff (por_req)
        wdt_req |=> cause_flags[B_WDT]);

    // R4
    a_r4_ill_flag: assert property (@(posedge clk) disable iff (por_req)
        (illegal_op_req || uninit_reg_req || security_req) |=> cause_flags[B_ILL]);

    // R5
    a_r5_flags_hold: assert property (@(posedge clk) disable iff (por_req)
        (!cause_wr_en && !warm_any && !bor_req && clr_pin_n && $past(clr_pin_n))
        |=> $stable(cause_flags));

    // R7
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (por_req)
        (cause_flags & ~IMPL_MASK) == '0);

    // R8
    a_r8_hw_beats_write: assert property (@(posedge clk) disable iff (por_req)
        (cause_wr_en && trap_conflict_req) |=> cause_flags[B_TRAP]);

    // R9
    a_r9_bor_cold: assert property (@(posedge clk) disable iff (por_req)
        bor_req |=> cold_rst);

    // R9
    a_r9_warm_start: assert property (@(posedge clk) disable iff (por_req)
        (warm_any && !bor_req && !sys_rst) |=> !cold_rst);
endmodule

bind reset_cause_hub reset_cause_hub_chk u_chk (
    .clk               (clk),
    .por_req           (por_req),
    .bor_req           (bor_req),
    .clr_pin_n         (clr_pin_n),
    .swrst_req         (swrst_req),
    .wdt_req           (wdt_req),
    .cfg_mismatch_req  (cfg_mismatch_req),
    .trap_conflict_req (trap_conflict_req),
    .illegal_op_req    (illegal_op_req),
    .uninit_reg_req    (uninit_reg_req),
    .security_req      (security_req),
    .cause_wr_en       (cause_wr_en),
    .sys_rst           (sys_rst),
    .cold_rst          (cold_rst),
    .cause_flags       (cause_flags)
);

// File: tb/reset_cause_hub_test.sv
`timescale 1ns/1ps
module reset_cause_hub_test;
    localparam logic [15:0] MASK = 16'h85D3;
    localparam logic [2:0]  CFG  = 3'b101;
    localparam logic [2:0]  CUR  = 3'b010;

    logic        clk = 1'b0;
    logic        por_req = 1'b1, bor_req = 1'b0, clr_pin_n = 1'b1;
    logic        swrst_req = 1'b0, wdt_req = 1'b0, cfg_mismatch_req = 1'b0;
    logic        trap_conflict_req = 1'b0, illegal_op_req = 1'b0;
    logic        uninit_reg_req = 1'b0, security_req = 1'b0;
    logic        cause_wr_en = 1'b0;
    logic [15:0] cause_wr_data = '0;
    logic [2:0]  cfg_osc_sel = CFG, cur_osc_sel = CUR;
    logic        sys_rst, cold_rst;
    logic [2:0]  clk_src_sel;
    logic [15:0] cause_flags;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reset_cause_hub uut (
        .clk(clk), .por_req(por_req), .bor_req(bor_req), .clr_pin_n(clr_pin_n),
        .swrst_req(swrst_req), .wdt_req(wdt_req), .cfg_mismatch_req(cfg_mismatch_req),
        .trap_conflict_req(trap_conflict_req), .illegal_op_req(illegal_op_req),
        .uninit_reg_req(uninit_reg_req), .security_req(security_req),
        .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
        .cfg_osc_sel(cfg_osc_sel), .cur_osc_sel(cur_osc_sel),
        .sys_rst(sys_rst), .cold_rst(cold_rst), .clk_src_sel(clk_src_sel),
        .cause_flags(cause_flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_src(input int idx, input logic v);
        case (idx)
            0: bor_req = v;
            1: swrst_req = v;
            2: wdt_req = v;
            3: cfg_mismatch_req = v;
            4: trap_conflict_req = v;
            5: illegal_op_req = v;
            6: uninit_reg_req = v;
            default: security_req = v;
        endcase
    endtask

    function automatic logic [15:0] src_bit(input int idx);
        case (idx)
            0: return 16'h0002;
            1: return 16'h0040;
            2: return 16'h0010;
            3: return 16'h0100;
            4: return 16'h8000;
            default: return 16'h0400;
        endcase
    endfunction

    task automatic sw_write(input logic [15:0] v);
        cause_wr_en = 1'b1; cause_wr_data = v;
        tick();
        cause_wr_en = 1'b0;
    endtask

    // counts further cycles with sys_rst high
    task automatic count_tail(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (sys_rst) n++;
            else break;
        end
    endtask

    initial begin
        int n;
        logic [15:0] exp;
        // power-on with a colliding write and warm source
        repeat (2) tick();
        cause_wr_en = 1'b1; cause_wr_data = 16'hFFFF; wdt_req = 1'b1;
        tick();
        cause_wr_en = 1'b0; wdt_req = 1'b0;
        tick();
        chk("R6 por value", cause_flags, 16'h0003);
        chk("R1 por asserts", sys_rst, 1);
        chk("R9 por cold", cold_rst, 1);
        chk("R10 cold select", clk_src_sel, CFG);
        por_req = 1'b0;
        count_tail(n);
        chk("R2 por tail", n, 8);
        chk("R5 flags after por release", cause_flags, 16'h0003);

        // sweep every non-pin source on its own
        for (int s = 0; s < 8; s++) begin
            sw_write(16'h0000);
            chk("R7 write no reset", sys_rst, 0);
            set_src(s, 1'b1);
            tick();
            set_src(s, 1'b0);
            chk("R1 source asserts", sys_rst, 1);
            chk("R4 flag position", cause_flags, src_bit(s));
            chk("R9 class", cold_rst, (s == 0) ? 1 : 0);
            chk("R10 select", clk_src_sel, (s == 0) ? CFG : CUR);
            count_tail(n);
            chk("R2 hold length", n, 8);
        end

        // R5: sticky across two warm resets
        sw_write(16'h0000);
        wdt_req = 1'b1; tick(); wdt_req = 1'b0;
        count_tail(n);
        trap_conflict_req = 1'b1; tick(); trap_conflict_req = 1'b0;
        count_tail(n);
        repeat (3) tick();
        chk("R5 sticky", cause_flags, 16'h8010);

        // R3: clear pin low pulse sweep
        for (int len = 1; len <= 7; len++) begin
            sw_write(16'h0000);
            n = 0;
            for (int c = 0; c < len + 16; c++) begin
                clr_pin_n = (c < len) ? 1'b0 : 1'b1;
                tick();
                if (sys_rst) n++;
            end
            chk("R3 pin reset cycles", n, (len >= 4) ? len + 5 : 0);
            chk("R3 pin flag", cause_flags, (len >= 4) ? 16'h0080 : 16'h0000);
        end

        // R7: walking-one writes
        for (int b = 0; b < 16; b++) begin
            sw_write(16'(1 << b));
            tick();
            chk("R7 walking write", cause_flags, 16'(1 << b) & MASK);
            chk("R7 write no reset", sys_rst, 0);
        end
        sw_write(16'hFFFF);
        chk("R7 full write masked", cause_flags, MASK);

        // R7: write accepted during reset
        sw_write(16'h0000);
        wdt_req = 1'b1; tick(); wdt_req = 1'b0;
        sw_write(16'h0040);
        chk("R7 write during reset", cause_flags, 16'h0040);
        chk("R7 reset still held", sys_rst, 1);
        count_tail(n);

        // R8: hardware set wins over same-cycle write
        cause_wr_en = 1'b1; cause_wr_data = 16'h0000; wdt_req = 1'b1;
        tick();
        cause_wr_en = 1'b0; wdt_req = 1'b0;
        chk("R8 write collision", cause_flags, 16'h0010);
        count_tail(n);
        sw_write(16'h0000);
        cfg_mismatch_req = 1'b1; uninit_reg_req = 1'b1; trap_conflict_req = 1'b1;
        tick();
        cfg_mismatch_req = 1'b0; uninit_reg_req = 1'b0; trap_conflict_req = 1'b0;
        chk("R8 simultaneous", cause_flags, 16'h8500);
        count_tail(n);
        chk("R2 simultaneous tail", n, 8);

        // R9: warm request inside a cold stretch keeps cold
        bor_req = 1'b1; tick(); bor_req = 1'b0;
        tick();
        swrst_req = 1'b1; tick(); swrst_req = 1'b0;
        chk("R9 warm during cold", cold_rst, 1);
        chk("R10 cold kept select", clk_src_sel, CFG);
        count_tail(n);
        chk("R2 extended tail", n, 8);
        exp = 16'h8500 | 16'h0002 | 16'h0040;
        chk("R5 accumulated", cause_flags, exp);

        // R6: power-on after flags are set
        por_req = 1'b1; tick(); por_req = 1'b0;
        chk("R6 por clears", cause_flags, 16'h0003);
        chk("R9 por cold again", cold_rst, 1);
        count_tail(n);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule